// File: doc/BRIEF.md
# Bridge Power and Soft-Reset Control Registers

This block is the control register set for a peripheral bridge. It sits on a simple 32-bit register bus and exposes four registers: a read-only revision word, a configuration register, a status register and a timing register. The configuration register sets how the bridge answers a power-management idle request. It also holds a self-clearing software reset and an auto-idle switch that gates the interface clock when the bus is quiet.

A software reset runs a fixed sequence of internal cycles. During that sequence the configuration and timing registers return to their power-on values. The status register reports when the sequence has finished. The timing fields are held here and passed on to the bridge. A write that programs the second synchronisation count below its safe minimum sets a sticky error flag.

The bus has no wait states. A transfer lasts the single cycle in which `bus_sel` is high. Read data is returned in that same cycle.

Top module: `bridge_ctl_regs`

## Requirements
- R1: After hardware reset the registers read as follows: revision at 0x00 reads the `REV_ID` parameter, configuration at 0x10 reads 0x11, status at 0x14 reads 0x1 and timing at 0x18 reads 0x001. `idle_ack`, `wake_req`, `srst_active` and `sync_err` are low.
- R2: A write to 0x10 stores the idle mode from bits 4:3 and auto-idle from bit 0. Bits 31:5, bit 2 and the soft-reset bit 1 always read as 0.
- R3: Writes to 0x00 and 0x14 have no effect. Reads of unmapped offsets return 0. `bus_rdata` is 0 whenever no read is in progress.
- R4: A write to 0x18 stores SYNC1 from bits 6:4 and SYNC2 from bits 3:0. The division ratio in bits 9:7 ignores writes and stays 0. Bits 31:10 read as 0. The three fields drive `tim_div`, `tim_sync1` and `tim_sync2`.
- R5: A timing write with SYNC2 below `SYNC2_MIN` (default 6) sets `sync_err`. The flag stays set until hardware reset.
- R6: A configuration write with bit 1 set starts a soft reset. `srst_active` is high for exactly `SRST_CYCLES` (default 8) cycles, starting the cycle after the write. The configuration and timing registers return to their R1 values. Register writes are ignored while `srst_active` is high.
- R7: Status bit 0 reads 0 while `srst_active` is high. It reads 1 again from the cycle after the sequence ends.
- R8: `idle_ack` is registered and follows inputs sampled one edge earlier. In mode 0 it equals `idle_req`. In mode 1 it is always 0.
- R9: In mode 2, `idle_ack` is high only when `idle_req` is high and there is no activity. Activity means `bus_sel`, `ext_busy` or a running soft reset. The acknowledge drops the cycle after activity appears.
- R10: Mode 3 acknowledges like mode 2. In addition, `wake_req` goes high one cycle after a cycle in which `idle_req` and `ext_busy` are both high. In all other modes `wake_req` stays 0.
- R11: `idle_ack` and `wake_req` are low in every cycle that `srst_active` is high, in every mode.
- R12: `iclk_en` is high whenever `bus_sel` is high or auto-idle is 0. Otherwise it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| bus_sel | input | 1 | Single-cycle register transfer strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| idle_req | input | 1 | Power-management idle request |
| ext_busy | input | 1 | Bridge datapath busy indication |
| idle_ack | output | 1 | Idle acknowledge |
| wake_req | output | 1 | Wakeup request (mode 3) |
| iclk_en | output | 1 | Interface clock enable |
| srst_active | output | 1 | Soft reset sequence in progress |
| sync_err | output | 1 | Sticky SYNC2-too-small error |
| tim_div | output | 3 | Division ratio to bridge |
| tim_sync1 | output | 3 | SYNC1 count to bridge |
| tim_sync2 | output | 4 | SYNC2 count to bridge |

## Verification
The properties assume that every input changes only between clock edges and that a transfer occupies exactly the one cycle in which `bus_sel` is high. They also assume that `idle_req` and `ext_busy` are synchronous to `clk`. The stimulus drives all inputs just after the falling edge. It draws addresses from the four mapped offsets and two unmapped ones, and it sets the soft-reset bit in only a small fraction of configuration writes. This lets long stretches of every idle mode run between reset sequences. Expected read data, acknowledges and flags come from a cycle-level model of the requirements that runs beside the design.

// File: rtl/brc_pkg.sv
package brc_pkg;

    localparam int DW          = 32;
    localparam int OFS_REV     = 'h00;
    localparam int OFS_CFG     = 'h10;
    localparam int OFS_STAT    = 'h14;
    localparam int OFS_TIM     = 'h18;
    localparam int SRST_BIT    = 1;

    typedef enum logic [1:0] {
        IDLE_FORCE      = 2'd0,
        IDLE_NEVER      = 2'd1,
        IDLE_SMART      = 2'd2,
        IDLE_SMART_WAKE = 2'd3
    } idle_mode_e;

    typedef struct packed {
        idle_mode_e mode;
        logic       autoidle;
    } cfg_t;

    typedef struct packed {
        logic [2:0] div;
        logic [2:0] sync1;
        logic [3:0] sync2;
    } timing_t;

    localparam cfg_t    CFG_DEFAULT = '{mode: IDLE_SMART, autoidle: 1'b1};
    localparam timing_t TIM_DEFAULT = '{div: 3'd0, sync1: 3'd0, sync2: 4'd1};

    function automatic logic [DW-1:0] cfg_word(input cfg_t c);
        return {{(DW-5){1'b0}}, c.mode, 2'b00, c.autoidle};
    endfunction

    function automatic logic [DW-1:0] tim_word(input timing_t t);
        return {{(DW-10){1'b0}}, t};
    endfunction

    // Raw acknowledge decision for one mode, before soft-reset blocking.
    function automatic logic idle_grant(input idle_mode_e m, input logic req,
                                        input logic active);
        logic g;
        unique case (m)
            IDLE_FORCE: g = req;
            IDLE_NEVER: g = 1'b0;
            default:    g = req & ~active;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/brc_regfile.sv
module brc_regfile
    import brc_pkg::*;
#(
    parameter int          ADDR_W    = 8,
    parameter logic [31:0] REV_ID    = 32'h0001_0203,
    parameter int          SYNC2_MIN = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    input  logic              srst_busy,
    input  logic              rst_done,
    output logic [DW-1:0]     bus_rdata,
    output cfg_t              cfg_q,
    output timing_t           tim_q,
    output logic              srst_start,
    output logic              sync_err
);

    localparam logic [ADDR_W-1:0] A_REV  = ADDR_W'(OFS_REV);
    localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(OFS_CFG);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_TIM  = ADDR_W'(OFS_TIM);

    logic wr_ok, cfg_hit, tim_hit, sync2_low;
    logic unused_wdata;

    assign wr_ok      = bus_sel & bus_wr & ~srst_busy;
    assign cfg_hit    = wr_ok && (bus_addr == A_CFG);
    assign tim_hit    = wr_ok && (bus_addr == A_TIM);
    assign srst_start = cfg_hit & bus_wdata[SRST_BIT];
    assign sync2_low  = bus_wdata[3:0] < 4'(SYNC2_MIN);
    assign unused_wdata = ^{bus_wdata[DW-1:10], bus_wdata[2]};

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q    <= CFG_DEFAULT;
            tim_q    <= TIM_DEFAULT;
            sync_err <= 1'b0;
        end else if (srst_start) begin
            cfg_q <= CFG_DEFAULT;
            tim_q <= TIM_DEFAULT;
        end else begin
            if (cfg_hit) begin
                cfg_q.mode     <= idle_mode_e'(bus_wdata[4:3]);
                cfg_q.autoidle <= bus_wdata[0];
            end
            if (tim_hit) begin
                tim_q.sync1 <= bus_wdata[6:4];
                tim_q.sync2 <= bus_wdata[3:0];
                if (sync2_low) sync_err <= 1'b1;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            unique case (bus_addr)
                A_REV:   bus_rdata = REV_ID;
                A_CFG:   bus_rdata = cfg_word(cfg_q);
                A_STAT:  bus_rdata = {{(DW-1){1'b0}}, rst_done};
                A_TIM:   bus_rdata = tim_word(tim_q);
                default: bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/brc_srst_seq.sv
module brc_srst_seq #(
    parameter int SRST_CYCLES = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic done
);

    localparam int CW = $clog2(SRST_CYCLES + 1);

    logic [CW-1:0] cnt;

    assign busy = (cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            done <= 1'b1;
        end else if (start) begin
            cnt  <= CW'(SRST_CYCLES);
            done <= 1'b0;
        end else if (busy) begin
            cnt <= cnt - 1'b1;
            if (cnt == CW'(1)) done <= 1'b1;
        end
    end

endmodule

// File: rtl/brc_idle_ctrl.sv
module brc_idle_ctrl
    import brc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  idle_mode_e mode,
    input  logic       autoidle,
    input  logic       idle_req,
    input  logic       ext_busy,
    input  logic       bus_sel,
    input  logic       srst_start,
    input  logic       srst_busy,
    output logic       idle_ack,
    output logic       wake_req,
    output logic       iclk_en
);

    logic active, blocked, ack_d, wake_d;

    assign active  = bus_sel | ext_busy | srst_busy;
    assign blocked = srst_start | srst_busy;
    assign ack_d   = ~blocked & idle_grant(mode, idle_req, active);
    assign wake_d  = ~blocked & (mode == IDLE_SMART_WAKE) & idle_req & ext_busy;
    assign iclk_en = bus_sel | ~autoidle;

    always_ff @(posedge clk) begin
        if (rst) begin
            idle_ack <= 1'b0;
            wake_req <= 1'b0;
        end else begin
            idle_ack <= ack_d;
            wake_req <= wake_d;
        end
    end

endmodule

// File: rtl/bridge_ctl_regs.sv
module bridge_ctl_regs
    import brc_pkg::*;
#(
    parameter int          ADDR_W      = 8,
    parameter logic [31:0] REV_ID      = 32'h0001_0203,
    parameter int          SYNC2_MIN   = 6,
    parameter int          SRST_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              idle_req,
    input  logic              ext_busy,
    output logic              idle_ack,
    output logic              wake_req,
    output logic              iclk_en,
    output logic              srst_active,
    output logic              sync_err,
    output logic [2:0]        tim_div,
    output logic [2:0]        tim_sync1,
    output logic [3:0]        tim_sync2
);

    cfg_t       cfg_q;
    timing_t    tim_q;
    logic       srst_start, srst_busy, rst_done;
    logic [1:0] cfg_mode;

    assign cfg_mode    = cfg_q.mode;
    assign srst_active = srst_busy;
    assign tim_div     = tim_q.div;
    assign tim_sync1   = tim_q.sync1;
    assign tim_sync2   = tim_q.sync2;

    brc_regfile #(
        .ADDR_W(ADDR_W), .REV_ID(REV_ID), .SYNC2_MIN(SYNC2_MIN)
    ) u_regs (
        .clk(clk), .rst(rst),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .srst_busy(srst_busy), .rst_done(rst_done),
        .bus_rdata(bus_rdata), .cfg_q(cfg_q), .tim_q(tim_q),
        .srst_start(srst_start), .sync_err(sync_err)
    );

    brc_srst_seq #(.SRST_CYCLES(SRST_CYCLES)) u_srst (
        .clk(clk), .rst(rst), .start(srst_start),
        .busy(srst_busy), .done(rst_done)
    );

    brc_idle_ctrl u_idle (
        .clk(clk), .rst(rst),
        .mode(cfg_q.mode), .autoidle(cfg_q.autoidle),
        .idle_req(idle_req), .ext_busy(ext_busy), .bus_sel(bus_sel),
        .srst_start(srst_start), .srst_busy(srst_busy),
        .idle_ack(idle_ack), .wake_req(wake_req), .iclk_en(iclk_en)
    );

endmodule

// File: rtl/brc_checker.sv
module brc_checker #(
    parameter int SRST_CYCLES = 8
) (
    input logic       clk,
    input logic       rst,
    input logic       bus_sel,
    input logic       ext_busy,
    input logic       idle_ack,
    input logic       wake_req,
    input logic       srst_active,
    input logic       sync_err,
    input logic       rst_done,
    input logic [1:0] mode
);

    localparam int RW = $clog2(SRST_CYCLES + 2);

    logic [RW-1:0] run;

    always_ff @(posedge clk) begin
        if (rst) run <= '0;
        else if (srst_active) run <= (run == RW'(SRST_CYCLES + 1)) ? run : run + 1'b1;
        else run <= '0;
    end

    a_r11_quiet_in_srst: assert property (@(posedge clk) disable iff (rst)
        srst_active |-> (!idle_ack && !wake_req));

    a_r9_drop_on_activity: assert property (@(posedge clk) disable iff (rst)
        (mode[1] && (bus_sel || ext_busy)) |=> !idle_ack);

    a_r8_never_mode: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd1) |=> !idle_ack);

    a_r6_srst_not_too_long: assert property (@(posedge clk) disable iff (rst)
        srst_active |-> (run < RW'(SRST_CYCLES)));

    a_r6_srst_full_length: assert property (@(posedge clk) disable iff (rst)
        $fell(srst_active) |-> (run == RW'(SRST_CYCLES)));

    a_r7_done_low_in_srst: assert property (@(posedge clk) disable iff (rst)
        srst_active |-> !rst_done);

    a_r7_done_after_srst: assert property (@(posedge clk) disable iff (rst)
        $fell(srst_active) |-> rst_done);

    a_r5_err_sticky: assert property (@(posedge clk) disable iff (rst)
        sync_err |=> sync_err);

    a_r10_wake_needs_busy: assert property (@(posedge clk) disable iff (rst)
        (!ext_busy || mode != 2'd3) |=> !wake_req);

endmodule

bind bridge_ctl_regs brc_checker #(.SRST_CYCLES(SRST_CYCLES)) u_chk (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .ext_busy(ext_busy),
    .idle_ack(idle_ack), .wake_req(wake_req), .srst_active(srst_active),
    .sync_err(sync_err), .rst_done(rst_done), .mode(cfg_mode)
);

// File: tb/tb_bridge_ctl_regs.sv
module tb_bridge_ctl_regs;

    localparam logic [31:0] REV = 32'h0001_0203;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_sel, bus_wr, idle_req, ext_busy;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic        idle_ack, wake_req, iclk_en, srst_active, sync_err;
    logic [2:0]  tim_div, tim_sync1;
    logic [3:0]  tim_sync2;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    // model state
    logic [1:0] m_mode;
    logic       m_ai, m_done, m_err;
    logic [2:0] m_s1;
    logic [3:0] m_s2;
    int         m_cnt;

    always #10 clk = ~clk;

    bridge_ctl_regs #(.REV_ID(REV)) dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .idle_req(idle_req), .ext_busy(ext_busy), .idle_ack(idle_ack),
        .wake_req(wake_req), .iclk_en(iclk_en), .srst_active(srst_active),
        .sync_err(sync_err), .tim_div(tim_div), .tim_sync1(tim_sync1),
        .tim_sync2(tim_sync2)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        case (a)
            8'h00:   return REV;
            8'h10:   return {27'd0, m_mode, 2'b00, m_ai};
            8'h14:   return {31'd0, m_done};
            8'h18:   return {22'd0, 3'd0, m_s1, m_s2};
            default: return 32'd0;
        endcase
    endfunction

    function automatic string read_tag(input logic [7:0] a);
        case (a)
            8'h10:   return "R2";
            8'h18:   return "R4";
            8'h14:   return "R7";
            default: return "R3";
        endcase
    endfunction

    // One bus cycle: drive, check combinational outputs, advance, check registered ones.
    task automatic step(input logic s, input logic w, input logic [7:0] a,
                        input logic [31:0] d, input logic rq, input logic bz,
                        input string tg);
        logic start, blk, act, e_ack, e_wake;
        string at;
        bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d;
        idle_req = rq; ext_busy = bz;
        #1;
        chk((tg != "") ? tg : read_tag(a), bus_rdata, (s && !w) ? exp_read(a) : 32'd0);
        chk("R12", {31'd0, iclk_en}, {31'd0, s || !m_ai});
        start = s && w && a == 8'h10 && d[1] && m_cnt == 0;
        blk   = start || m_cnt != 0;
        act   = s || bz || m_cnt != 0;
        e_ack = blk ? 1'b0 : (m_mode == 2'd0) ? rq : (m_mode == 2'd1) ? 1'b0 : (rq && !act);
        e_wake = !blk && m_mode == 2'd3 && rq && bz;
        at = blk ? "R11" : (m_mode[1] == 1'b0) ? "R8" : (m_mode == 2'd2) ? "R9" : "R10";
        if (start) begin
            m_mode = 2'd2; m_ai = 1'b1; m_s1 = 3'd0; m_s2 = 4'd1;
            m_cnt = 8; m_done = 1'b0;
        end else if (m_cnt != 0) begin
            if (m_cnt == 1) m_done = 1'b1;
            m_cnt--;
        end else if (s && w) begin
            if (a == 8'h10) begin m_mode = d[4:3]; m_ai = d[0]; end
            if (a == 8'h18) begin
                m_s1 = d[6:4]; m_s2 = d[3:0];
                if (d[3:0] < 4'd6) m_err = 1'b1;
            end
        end
        @(posedge clk);
        @(negedge clk);
        chk(at, {31'd0, idle_ack}, {31'd0, e_ack});
        chk("R10", {31'd0, wake_req}, {31'd0, e_wake});
        chk("R6", {31'd0, srst_active}, {31'd0, m_cnt != 0});
        chk("R5", {31'd0, sync_err}, {31'd0, m_err});
        chk("R4", {22'd0, tim_div, tim_sync1, tim_sync2}, {22'd0, 3'd0, m_s1, m_s2});
    endtask

    task automatic rd(input logic [7:0] a, input string tg);
        step(1'b1, 1'b0, a, 32'd0, 1'b0, 1'b0, tg);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        step(1'b1, 1'b1, a, d, 1'b0, 1'b0, "");
    endtask

    task automatic idle(input logic rq, input logic bz);
        step(1'b0, 1'b0, 8'h00, 32'd0, rq, bz, "");
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int srst_len;
        logic [7:0] addrs [6];
        addrs = '{8'h00, 8'h10, 8'h14, 8'h18, 8'h04, 8'h1C};
        void'($urandom(32'd20240611));
        rst = 1'b1; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
        idle_req = 0; ext_busy = 0;
        m_mode = 2'd2; m_ai = 1; m_done = 1; m_err = 0; m_s1 = 0; m_s2 = 1; m_cnt = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        chk("R1", {28'd0, idle_ack, wake_req, srst_active, sync_err}, 32'd0);
        rd(8'h00, "R1"); rd(8'h10, "R1"); rd(8'h14, "R1"); rd(8'h18, "R1");

        // R3: writes to read-only registers ignored, unmapped reads zero
        wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, "R3");
        wr(8'h14, 32'h0);         rd(8'h14, "R3");
        rd(8'h04, "R3"); rd(8'h20, "R3");

        // R2 / R4: field placement, division ratio ignored
        wr(8'h10, 32'hFFFF_FFFD); rd(8'h10, "R2");
        wr(8'h18, 32'hFFFF_FFFF); rd(8'h18, "R4");

        // R5: small SYNC2 sets sticky error, later valid write keeps it
        wr(8'h18, 32'h0000_0023); idle(0, 0);
        wr(8'h18, 32'h0000_0008); idle(0, 0);

        // R8: mode 1 never, mode 0 always even when busy
        wr(8'h10, 32'h09); repeat (4) idle(1, 1);
        wr(8'h10, 32'h01); repeat (3) idle(1, 1); idle(0, 0);
        // R9 / R10: smart modes
        wr(8'h10, 32'h11); idle(1, 0); idle(1, 0); idle(1, 1); idle(1, 0);
        wr(8'h10, 32'h19); idle(1, 1); idle(1, 0); idle(1, 1); idle(0, 1);
        // R12: free-running clock enable
        wr(8'h10, 32'h10); idle(0, 0); idle(1, 0); rd(8'h10, "R12");

        // R6 / R7 / R11: soft reset in force mode with a pending request
        wr(8'h10, 32'h01); idle(1, 0);
        wr(8'h18, 32'h77);
        step(1'b1, 1'b1, 8'h10, 32'h0000_0002, 1'b1, 1'b0, "");
        srst_len = 0;
        while (srst_active && srst_len < 20) begin
            srst_len++;
            if (srst_len == 3) wr(8'h18, 32'h55);
            else if (srst_len == 4) wr(8'h10, 32'h09);
            else rd(8'h14, "R7");
        end
        chk("R6", srst_len, 8);
        rd(8'h14, "R7"); rd(8'h10, "R6"); rd(8'h18, "R6");
        idle(1, 0); idle(1, 0);

        // Random phase
        for (int i = 0; i < 2000; i++) begin
            logic [7:0] a;
            logic [31:0] d;
            int k;
            k = $urandom % 8;
            a = addrs[$urandom % 6];
            d = $urandom;
            if (a == 8'h10 && ($urandom % 24) != 0) d[1] = 1'b0;
            if (k < 2)      step(1'b1, 1'b1, a, d, $urandom % 2, $urandom % 4 == 0, "");
            else if (k < 4) step(1'b1, 1'b0, a, 32'd0, $urandom % 2, $urandom % 4 == 0, "");
            else            step(1'b0, 1'b0, a, 32'd0, $urandom % 4 != 0, $urandom % 3 == 0, "");
        end

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule